// File: doc/BRIEF.md
# Double-Buffered Time-Slot Routing RAM

This block holds the slot routing tables of a time-division multiplexed serial interface with up to four TDM ports. Every port has a receive table and a transmit table. Each table has two banks: the original bank (index 0) and the shadow bank (index 1). At any moment one bank per direction and port is live and the other is idle. A per-port slot sequencer walks the live bank one entry per slot step and reports whether the current slot belongs to a multichannel controller and, if so, which channel owns it.

Software edits the idle bank through a host port. The host port offers plain read and write and two read-modify-write operations: one adds a channel to a slot and one removes it while keeping the slot attribute bits. Software then writes a command byte that requests a bank swap. The swap is held pending and takes effect only at that port's next frame sync, so the sequencer never changes tables in the middle of a frame. A status byte reports the live bank of every direction and port. A sticky flag records any host modification of a live bank.

Top module: `tsr_route_ram`

## Requirements
- R1: After reset, every entry of every bank is 0x0000, the status byte is 0x00 (all original banks live), the live-write flag is 0, host read data is 0 and every slot output reports unassigned.
- R2: A host address selects bank `addr / ENTRIES` (the top address bit) and entry `addr % ENTRIES`, within the table picked by direction (0 receive, 1 transmit) and port. Op code 01 writes the data. Op code 00 reads, and the data appears on the read output after the next clock edge and holds until the next read.
- R3: Op code 10 (assign) ORs 0x8000 and the channel number (low 10 bits of the write data) shifted left by 5 into the addressed entry.
- R4: Op code 11 (remove) clears the addressed entry except bits 4:0.
- R5: A frame sync on a port sets its slot index to 0. A slot step without a frame sync advances the index by one, and the index wraps from ENTRIES-1 to 0. A frame sync takes priority over a slot step in the same cycle.
- R6: For each port and direction, the slot output is valid exactly when bit 15 of the live bank's entry at the current index is set. When it is valid, the channel output is bits 14:5 of that entry. When it is not valid, the channel output is 0.
- R7: Status bit 7-2t is the receive bank of port t and status bit 6-2t is its transmit bank. A bit value of 1 means the shadow bank is live.
- R8: A command write with a bit set in the status bit layout requests a swap of that direction and port. The status bit and the slot outputs keep the old bank until the port's next frame sync. The new bank appears in the same edge that resets the index to 0.
- R9: A request that arrives in the same cycle as a frame sync waits for the following frame sync. Several requests for one direction and port before a frame sync cause a single swap.
- R10: A write, assign or remove that targets the live bank still updates the entry and sets the live-write flag, which then stays set until reset. The same operations on the idle bank leave the flag unchanged.
- R11: Receive and transmit banks swap independently. A request for one direction leaves the other direction's bank and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host operation strobe |
| host_op | input | 2 | 00 read, 01 write, 10 assign channel, 11 remove channel |
| host_dir | input | 1 | 0 receive table, 1 transmit table |
| host_port | input | 2 | TDM port index |
| host_addr | input | 6 | bank * ENTRIES + entry |
| host_wdata | input | 16 | Write data, or channel number in bits 9:0 for assign |
| host_rdata | output | 16 | Read data, registered |
| cmd_we | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Swap request bits, same layout as status |
| status | output | 8 | Live bank per direction and port |
| live_wr_err | output | 1 | Sticky flag for a modification of a live bank |
| frame_sync | input | 4 | Per-port frame boundary pulse |
| slot_step | input | 4 | Per-port slot advance pulse |
| rx_valid | output | 4 | Per-port receive slot assigned |
| rx_chan | output | 40 | Per-port receive channel, 10 bits per port |
| tx_valid | output | 4 | Per-port transmit slot assigned |
| tx_chan | output | 40 | Per-port transmit channel, 10 bits per port |

## Verification
The assertions assume that reset is held for at least one edge and that host addresses fall within a bank, which holds for the power-of-two default entry count. They also assume that the command byte and the frame syncs are single-cycle pulses sampled only at clock edges. The random stimulus draws addresses from the full bank range, keeps ports within the configured count, and mixes frame syncs, slot steps, command writes and host operations on both live and idle banks in any combination per cycle. This includes a command in the same cycle as a frame sync. Directed sequences cover a swap requested mid-frame, index wrap, and the attribute bits that a remove keeps.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int ENTRY_W   = 16;
    localparam int VALID_BIT = 15;
    localparam int CH_LSB    = 5;
    localparam int CH_W      = 10;
    localparam int STAT_W    = 8;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_ASSIGN = 2'b10,
        OP_CLEAR  = 2'b11
    } host_op_e;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
    } slot_info_t;

    function automatic logic [ENTRY_W-1:0] entry_assign(logic [ENTRY_W-1:0] old_e,
                                                        logic [CH_W-1:0] ch);
        return old_e | {1'b1, ch, {CH_LSB{1'b0}}};
    endfunction

    function automatic logic [ENTRY_W-1:0] entry_clear(logic [ENTRY_W-1:0] old_e);
        return old_e & {{(ENTRY_W-CH_LSB){1'b0}}, {CH_LSB{1'b1}}};
    endfunction

    function automatic slot_info_t slot_decode(logic [ENTRY_W-1:0] e);
        slot_info_t s;
        s.valid = e[VALID_BIT];
        s.chan  = e[VALID_BIT] ? e[VALID_BIT-1:CH_LSB] : '0;
        return s;
    endfunction

    function automatic int rx_stat_bit(int t);
        return STAT_W - 1 - 2 * t;
    endfunction

    function automatic int tx_stat_bit(int t);
        return STAT_W - 2 - 2 * t;
    endfunction

endpackage

// File: rtl/tsr_bank_ctl.sv
module tsr_bank_ctl #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    input  logic             step,
    input  logic             req_rx,
    input  logic             req_tx,
    output logic             bank_rx,
    output logic             bank_tx,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic pend_rx, pend_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            bank_rx <= 1'b0;
            bank_tx <= 1'b0;
            pend_rx <= 1'b0;
            pend_tx <= 1'b0;
        end else if (fsync) begin
            idx     <= '0;
            bank_rx <= bank_rx ^ pend_rx;
            bank_tx <= bank_tx ^ pend_tx;
            pend_rx <= req_rx;
            pend_tx <= req_tx;
        end else begin
            if (step) idx <= (idx == LAST) ? '0 : idx + 1'b1;
            pend_rx <= pend_rx | req_rx;
            pend_tx <= pend_tx | req_tx;
        end
    end

    AST_BANK_ONLY_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
        !fsync |=> ($stable(bank_rx) && $stable(bank_tx)));                         // R8
    AST_RX_SWAP_APPLIED: assert property (@(posedge clk) disable iff (rst)
        (fsync && pend_rx) |=> (bank_rx != $past(bank_rx)));                        // R8
    AST_TX_HELD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (fsync && !pend_tx) |=> $stable(bank_tx));                                   // R11
    AST_SYNC_ZERO_IDX: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (idx == '0));                                                      // R5
    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!fsync && step) |=> (idx == (($past(idx) == LAST) ? '0 : $past(idx) + 1'b1))); // R5

endmodule

// File: rtl/tsr_table.sv
module tsr_table
    import tsr_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ENTRIES   = 32,
    parameter int IDX_W     = 5,
    parameter int PORT_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           host_en,
    input  host_op_e                       op,
    input  logic                           dir,
    input  logic [PORT_W-1:0]              port,
    input  logic                           bank,
    input  logic [IDX_W-1:0]               k,
    input  logic [ENTRY_W-1:0]             wdata,
    output logic [ENTRY_W-1:0]             rdata,
    input  logic [NUM_PORTS-1:0]           rx_bank,
    input  logic [NUM_PORTS-1:0]           tx_bank,
    input  logic [NUM_PORTS*IDX_W-1:0]     idx_flat,
    output logic [NUM_PORTS*ENTRY_W-1:0]   rx_entry,
    output logic [NUM_PORTS*ENTRY_W-1:0]   tx_entry
);

    logic [ENTRY_W-1:0] mem [2][NUM_PORTS][2][ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            for (int d = 0; d < 2; d++)
                for (int p = 0; p < NUM_PORTS; p++)
                    for (int b = 0; b < 2; b++)
                        for (int e = 0; e < ENTRIES; e++)
                            mem[d][p][b][e] <= '0;
        end else if (host_en) begin
            unique case (op)
                OP_READ:   rdata <= mem[dir][port][bank][k];
                OP_WRITE:  mem[dir][port][bank][k] <= wdata;
                OP_ASSIGN: mem[dir][port][bank][k] <=
                               entry_assign(mem[dir][port][bank][k], wdata[CH_W-1:0]);
                OP_CLEAR:  mem[dir][port][bank][k] <= entry_clear(mem[dir][port][bank][k]);
                default:   ;
            endcase
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot_read
        assign rx_entry[p*ENTRY_W +: ENTRY_W] =
            mem[0][p][rx_bank[p]][idx_flat[p*IDX_W +: IDX_W]];
        assign tx_entry[p*ENTRY_W +: ENTRY_W] =
            mem[1][p][tx_bank[p]][idx_flat[p*IDX_W +: IDX_W]];
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(host_en && op == OP_READ) |=> $stable(rdata));                             // R2

endmodule

// File: rtl/tsr_route_ram.sv
module tsr_route_ram
    import tsr_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ENTRIES   = 32,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int AW       = IDX_W + 1,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_en,
    input  logic [1:0]                host_op,
    input  logic                      host_dir,
    input  logic [PORT_W-1:0]         host_port,
    input  logic [AW-1:0]             host_addr,
    input  logic [ENTRY_W-1:0]        host_wdata,
    output logic [ENTRY_W-1:0]        host_rdata,
    input  logic                      cmd_we,
    input  logic [STAT_W-1:0]         cmd_data,
    output logic [STAT_W-1:0]         status,
    output logic                      live_wr_err,
    input  logic [NUM_PORTS-1:0]      frame_sync,
    input  logic [NUM_PORTS-1:0]      slot_step,
    output logic [NUM_PORTS-1:0]      rx_valid,
    output logic [NUM_PORTS*CH_W-1:0] rx_chan,
    output logic [NUM_PORTS-1:0]      tx_valid,
    output logic [NUM_PORTS*CH_W-1:0] tx_chan
);

    host_op_e                     op;
    logic                         host_bank;
    logic [IDX_W-1:0]             host_k;
    logic                         live_bank;
    logic [NUM_PORTS-1:0]         bank_rx, bank_tx, req_rx, req_tx;
    logic [NUM_PORTS*IDX_W-1:0]   idx_flat;
    logic [NUM_PORTS*ENTRY_W-1:0] rx_entry, tx_entry;

    assign op        = host_op_e'(host_op);
    assign host_bank = host_addr[AW-1];
    assign host_k    = host_addr[IDX_W-1:0];
    assign live_bank = host_dir ? bank_tx[host_port] : bank_rx[host_port];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        slot_info_t rx_s, tx_s;

        assign req_rx[p] = cmd_we & cmd_data[rx_stat_bit(p)];
        assign req_tx[p] = cmd_we & cmd_data[tx_stat_bit(p)];

        tsr_bank_ctl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctl (
            .clk     (clk),
            .rst     (rst),
            .fsync   (frame_sync[p]),
            .step    (slot_step[p]),
            .req_rx  (req_rx[p]),
            .req_tx  (req_tx[p]),
            .bank_rx (bank_rx[p]),
            .bank_tx (bank_tx[p]),
            .idx     (idx_flat[p*IDX_W +: IDX_W])
        );

        assign rx_s = slot_decode(rx_entry[p*ENTRY_W +: ENTRY_W]);
        assign tx_s = slot_decode(tx_entry[p*ENTRY_W +: ENTRY_W]);
        assign rx_valid[p]               = rx_s.valid;
        assign rx_chan[p*CH_W +: CH_W]   = rx_s.chan;
        assign tx_valid[p]               = tx_s.valid;
        assign tx_chan[p*CH_W +: CH_W]   = tx_s.chan;
    end

    always_comb begin
        status = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            status[rx_stat_bit(p)] = bank_rx[p];
            status[tx_stat_bit(p)] = bank_tx[p];
        end
    end

    tsr_table #(
        .NUM_PORTS (NUM_PORTS),
        .ENTRIES   (ENTRIES),
        .IDX_W     (IDX_W),
        .PORT_W    (PORT_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .host_en  (host_en),
        .op       (op),
        .dir      (host_dir),
        .port     (host_port),
        .bank     (host_bank),
        .k        (host_k),
        .wdata    (host_wdata),
        .rdata    (host_rdata),
        .rx_bank  (bank_rx),
        .tx_bank  (bank_tx),
        .idx_flat (idx_flat),
        .rx_entry (rx_entry),
        .tx_entry (tx_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) live_wr_err <= 1'b0;
        else if (host_en && op != OP_READ && host_bank == live_bank) live_wr_err <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        live_wr_err |=> live_wr_err);                                                // R10
    AST_ERR_ON_LIVE: assert property (@(posedge clk) disable iff (rst)
        (host_en && op != OP_READ && host_bank == live_bank) |=> live_wr_err);      // R10
    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (frame_sync == '0) |=> $stable(status));                                     // R8

endmodule

// File: tb/tb_tsr_route_ram.sv
module tb_tsr_route_ram;

    localparam int NP = 4;
    localparam int E  = 32;
    localparam int CW = 10;

    logic           clk = 1'b0;
    logic           rst;
    logic           host_en, host_dir, cmd_we;
    logic [1:0]     host_op, host_port;
    logic [5:0]     host_addr;
    logic [15:0]    host_wdata, host_rdata;
    logic [7:0]     cmd_data, status;
    logic           live_wr_err;
    logic [NP-1:0]  frame_sync, slot_step, rx_valid, tx_valid;
    logic [NP*CW-1:0] rx_chan, tx_chan;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] mm [2][NP][2][E];
    logic [15:0] m_rdata;
    logic        m_err;
    logic [NP-1:0] m_brx, m_btx, m_prx, m_ptx;
    int          m_idx [NP];

    always #5 clk = ~clk;

    tsr_route_ram dut (
        .clk(clk), .rst(rst), .host_en(host_en), .host_op(host_op), .host_dir(host_dir),
        .host_port(host_port), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .cmd_we(cmd_we), .cmd_data(cmd_data), .status(status),
        .live_wr_err(live_wr_err), .frame_sync(frame_sync), .slot_step(slot_step),
        .rx_valid(rx_valid), .rx_chan(rx_chan), .tx_valid(tx_valid), .tx_chan(tx_chan)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [7:0] s = '0;
        for (int p = 0; p < NP; p++) begin
            s[7-2*p] = m_brx[p];
            s[6-2*p] = m_btx[p];
        end
        return s;
    endfunction

    function automatic logic [10:0] exp_slot(int d, int p);
        logic [15:0] e = mm[d][p][d ? m_btx[p] : m_brx[p]][m_idx[p]];
        return e[15] ? {1'b1, e[14:5]} : 11'h0;
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < NP; p++)
                for (int b = 0; b < 2; b++)
                    for (int e = 0; e < E; e++) mm[d][p][b][e] = '0;
        m_rdata = '0; m_err = 1'b0;
        m_brx = '0; m_btx = '0; m_prx = '0; m_ptx = '0;
        for (int p = 0; p < NP; p++) m_idx[p] = 0;
    endtask

    task automatic model_update();
        if (host_en) begin
            int d = host_dir;
            int p = host_port;
            int b = host_addr[5];
            int k = host_addr[4:0];
            logic live = host_dir ? m_btx[p] : m_brx[p];
            if (host_op != 2'b00 && b == int'(live)) m_err = 1'b1;
            case (host_op)
                2'b00: m_rdata = mm[d][p][b][k];
                2'b01: mm[d][p][b][k] = host_wdata;
                2'b10: mm[d][p][b][k] = mm[d][p][b][k] | 16'h8000 | {1'b0, host_wdata[9:0], 5'b0};
                default: mm[d][p][b][k] = mm[d][p][b][k] & 16'h001F;
            endcase
        end
        for (int p = 0; p < NP; p++) begin
            logic rr = cmd_we & cmd_data[7-2*p];
            logic rt = cmd_we & cmd_data[6-2*p];
            if (frame_sync[p]) begin
                m_idx[p] = 0;
                m_brx[p] = m_brx[p] ^ m_prx[p];
                m_btx[p] = m_btx[p] ^ m_ptx[p];
                m_prx[p] = rr;
                m_ptx[p] = rt;
            end else begin
                if (slot_step[p]) m_idx[p] = (m_idx[p] == E - 1) ? 0 : m_idx[p] + 1;
                m_prx[p] = m_prx[p] | rr;
                m_ptx[p] = m_ptx[p] | rt;
            end
        end
    endtask

    task automatic full_check();
        chk("R7 status", status, exp_status());
        chk("R10 live_wr_err", live_wr_err, m_err);
        chk("R2 host_rdata", host_rdata, m_rdata);
        for (int p = 0; p < NP; p++) begin
            chk("R6 rx slot", {rx_valid[p], rx_chan[p*CW +: CW]}, exp_slot(0, p));
            chk("R6 tx slot", {tx_valid[p], tx_chan[p*CW +: CW]}, exp_slot(1, p));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst) model_update();
        #1;
        if (!rst) full_check();
    endtask

    task automatic idle_inputs();
        host_en = 0; host_op = 0; host_dir = 0; host_port = 0; host_addr = 0;
        host_wdata = 0; cmd_we = 0; cmd_data = 0; frame_sync = 0; slot_step = 0;
    endtask

    task automatic host(logic [1:0] op, logic d, logic [1:0] p, logic [5:0] a, logic [15:0] w);
        host_en = 1; host_op = op; host_dir = d; host_port = p; host_addr = a; host_wdata = w;
        tick();
        host_en = 0;
    endtask

    task automatic sync(logic [NP-1:0] f);
        frame_sync = f; tick(); frame_sync = '0;
    endtask

    task automatic steps(int port, int n);
        for (int i = 0; i < n; i++) begin
            slot_step[port] = 1'b1; tick(); slot_step[port] = 1'b0;
        end
    endtask

    task automatic cmd(logic [7:0] c);
        cmd_we = 1; cmd_data = c; tick(); cmd_we = 0; cmd_data = 0;
    endtask

    initial begin
        #(10 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        idle_inputs();
        model_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 err", live_wr_err, 1'b0);
        chk("R1 rdata", host_rdata, 16'h0);
        chk("R1 valid", {rx_valid, tx_valid}, 8'h00);

        // R2 write then read on the shadow bank (addr 32 + 3)
        host(2'b01, 0, 1, 6'd35, 16'hABCD);
        host(2'b00, 0, 1, 6'd35, 16'h0);
        chk("R2 readback", host_rdata, 16'hABCD);
        host(2'b00, 0, 1, 6'd3, 16'h0);
        chk("R2 bank0 separate", host_rdata, 16'h0000);
        // R3 assign channel 0x155
        host(2'b10, 0, 1, 6'd35, 16'h0155);
        host(2'b00, 0, 1, 6'd35, 16'h0);
        chk("R3 assign", host_rdata, 16'hABED);
        // R4 remove keeps bits 4:0
        host(2'b11, 0, 1, 6'd35, 16'h0);
        host(2'b00, 0, 1, 6'd35, 16'h0);
        chk("R4 remove", host_rdata, 16'h000D);
        chk("R10 idle bank writes", live_wr_err, 1'b0);

        // fill port 0 receive: shadow gets 100+k, original gets 200+k
        for (int k = 0; k < 8; k++) host(2'b10, 0, 0, 6'(32 + k), 16'(100 + k));
        chk("R10 still clear", live_wr_err, 1'b0);
        for (int k = 0; k < 8; k++) host(2'b10, 0, 0, 6'(k), 16'(200 + k));
        chk("R10 live write flagged", live_wr_err, 1'b1);

        // mid-frame swap
        sync(4'b0001);
        steps(0, 3);
        chk("R6 slot3 chan", {rx_valid[0], rx_chan[9:0]}, {1'b1, 10'd203});
        cmd(8'h80);
        chk("R8 status held", status, 8'h00);
        chk("R8 chan held", rx_chan[9:0], 10'd203);
        steps(0, 2);
        chk("R8 still old bank", rx_chan[9:0], 10'd205);
        sync(4'b0001);
        chk("R8 swapped status", status, 8'h80);
        chk("R8 swapped chan", rx_chan[9:0], 10'd100);
        chk("R11 tx untouched", status[6], 1'b0);

        // R9 same-cycle command waits
        cmd_we = 1; cmd_data = 8'h80; frame_sync = 4'b0001; tick();
        cmd_we = 0; cmd_data = 0; frame_sync = 0;
        chk("R9 same cycle deferred", status, 8'h80);
        sync(4'b0001);
        chk("R9 applied next sync", status, 8'h00);
        cmd(8'h80); cmd(8'h80);
        sync(4'b0001);
        chk("R9 single toggle", status, 8'h80);

        // R11 transmit toggle independent
        cmd(8'h40);
        sync(4'b0001);
        chk("R11 tx toggled", status, 8'hC0);
        chk("R11 rx chan kept", rx_chan[9:0], 10'd100);

        // R7 other port bit positions
        cmd(8'h08);
        sync(4'b0100);
        chk("R7 port2 rx bit", status, 8'hC8);
        cmd(8'h01);
        sync(4'b1000);
        chk("R7 port3 tx bit", status, 8'hC9);

        // R5 wrap
        steps(0, E);
        chk("R5 wrap to slot0", rx_chan[9:0], 10'd100);
        steps(0, 1);
        chk("R5 slot1 after wrap", rx_chan[9:0], 10'd101);
        slot_step = 4'b0001; frame_sync = 4'b0001; tick(); idle_inputs();
        chk("R5 sync beats step", rx_chan[9:0], 10'd100);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            host_en    = ($urandom % 2) == 0;
            host_op    = 2'($urandom % 4);
            host_dir   = 1'($urandom % 2);
            host_port  = 2'($urandom % NP);
            host_addr  = 6'($urandom % (2 * E));
            host_wdata = 16'($urandom);
            cmd_we     = ($urandom % 16) == 0;
            cmd_data   = 8'($urandom);
            for (int p = 0; p < NP; p++) begin
                frame_sync[p] = ($urandom % 32) == 0;
                slot_step[p]  = ($urandom % 8) < 5;
            end
            tick();
        end
        idle_inputs();
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule